// File: doc/BRIEF.md
# Receive FIFO Frame Fetcher

This block pulls received frames out of a word-wide receive FIFO port. The port signals a pending frame with a frame-pending flag and a readable word stream with a data-available flag. When a frame is pending, the fetcher acknowledges it and then polls for data a bounded number of times at a fixed interval. Once data is available it reads a fixed-size receive header and checks the frame length and two status flags. A frame that fails a check is thrown away by pulsing a discard strobe back to the port. A frame that passes is turned into a byte stream with start and end markers. When the header asks for alignment, two zero pad bytes are placed ahead of the payload.

Each problem ends the frame with a one-cycle error report: a poll timeout, a bad length, a bad checksum, or hitting the limit on back-to-back frames. A configuration input lets frames with a failed checksum pass through. A guard counter stops the fetcher from draining forever while the frame-pending flag stays high.

Top module: `pio_rx_fetch`

## Requirements
- R1: After synchronous reset every output is 0 and the fetcher waits in its idle state.
- R2: `frame_ack` pulses for exactly one cycle, and only after `frame_rdy` was seen high in idle. While `frame_rdy` is low there is no acknowledge, no pop and no byte.
- R3: After the acknowledge, `data_rdy` is sampled `POLL_TRIES` times, `POLL_GAP` cycles apart, with the first sample in the cycle after the acknowledge. If it is never seen, `err_code` 1 (timeout) is reported in the last sample cycle. Nothing is popped, and the fetcher returns to idle.
- R4: Once `data_rdy` is seen, `HDR_WORDS` header words are popped, one per cycle. The frame length is word 0 bits [15:0]. Word 1 bit 0 is the checksum-error flag and word 1 bit 2 is the padding flag.
- R5: A length of 0 or greater than 0x700 reports `err_code` 2 together with a one-cycle `discard` pulse, and emits no byte. A length of exactly 0x700 is accepted.
- R6: With the checksum-error flag set and `pass_bad_fcs` low, the frame reports `err_code` 3 with a `discard` pulse. With `pass_bad_fcs` high the frame is delivered. The length check takes priority over the checksum check.
- R7: With the padding flag set, two 0x00 bytes come before the payload, and `byte_sop` marks the first pad byte.
- R8: Payload bytes leave least significant byte first, one per cycle. A word is popped in the cycle its last used byte leaves. In a partial final word only the low bytes are used.
- R9: Each delivered frame has exactly one `byte_sop`, on its first byte, and one `byte_eop`, on its last byte. `byte_valid` is low in the cycle after `byte_eop`.
- R10: After `MAX_FRAMES` acknowledges with no idle cycle that sees `frame_rdy` low, the next pending frame reports `err_code` 4 instead of an acknowledge. No further acknowledge is given until `frame_rdy` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pass_bad_fcs | input | 1 | Deliver frames whose checksum-error flag is set |
| frame_rdy | input | 1 | FIFO reports a frame pending |
| data_rdy | input | 1 | FIFO reports frame words readable |
| rd_word | input | 32 | Word at the FIFO head |
| frame_ack | output | 1 | Acknowledge of the pending frame |
| discard | output | 1 | Tells the FIFO to drop the current frame |
| rd_pop | output | 1 | Consume the head word |
| byte_valid | output | 1 | Output byte present |
| byte_data | output | 8 | Output byte |
| byte_sop | output | 1 | First byte of a frame |
| byte_eop | output | 1 | Last byte of a frame |
| err_valid | output | 1 | Error report strobe |
| err_code | output | 3 | 1 timeout, 2 length, 3 checksum, 4 burst limit |

## Verification
Frames are sent with payload lengths 1, 5, 6 and 0x700, so that full words, partial final words and the single-byte case, where start and end fall on one byte, all get tested. The padded 5-byte frame separates the pad insertion from the payload unpacking. Lengths 0 and 0x701 bound the length check from both sides. A frame with both a zero length and the checksum flag set shows which check wins. Late data inside the poll window, data that never arrives, and a frame-pending flag held high separate a slow frame from a timeout and from the burst guard.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_TIMEOUT = 3'd1,
        ERR_LENGTH  = 3'd2,
        ERR_FCS     = 3'd3,
        ERR_BURST   = 3'd4
    } rxf_err_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ACK, S_POLL, S_HDR, S_CHECK, S_PAD, S_DATA, S_HOLD
    } rxf_state_e;

    localparam logic [15:0] LEN_LIMIT = 16'h0700;
    localparam int          FCS_BIT   = 0;
    localparam int          PAD_BIT   = 2;

    typedef struct packed {
        logic [15:0] len;
        logic        fcs_bad;
        logic        pad;
    } rxf_hdr_t;

    function automatic rxf_err_e judge(input rxf_hdr_t h, input logic pass_fcs);
        if (h.len == 16'd0 || h.len > LEN_LIMIT) return ERR_LENGTH;
        if (h.fcs_bad && !pass_fcs)              return ERR_FCS;
        return ERR_NONE;
    endfunction

endpackage

// File: rtl/rxf_poll_timer.sv
module rxf_poll_timer #(
    parameter int TRIES = 10,
    parameter int GAP   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic sample,
    output logic last
);
    localparam int GAP_W = $clog2(GAP) + 1;
    localparam int TRY_W = $clog2(TRIES) + 1;

    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] try_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            gap_q <= '0;
            try_q <= '0;
        end else if (run) begin
            if (gap_q == '0) begin
                gap_q <= GAP_W'(GAP - 1);
                try_q <= try_q + 1'b1;
            end else begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign sample = run && (gap_q == '0);
    assign last   = (try_q == TRY_W'(TRIES - 1));
endmodule

// File: rtl/rxf_hdr_check.sv
module rxf_hdr_check
    import rxf_pkg::*;
(
    input  rxf_hdr_t hdr,
    input  logic     pass_fcs,
    output rxf_err_e verdict
);
    always_comb verdict = judge(hdr, pass_fcs);
endmodule

// File: rtl/rxf_burst_guard.sv
module rxf_burst_guard #(
    parameter int MAX_FRAMES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic take,
    output logic limit
);
    localparam int CNT_W = $clog2(MAX_FRAMES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (take && !limit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign limit = (cnt_q == CNT_W'(MAX_FRAMES));
endmodule

// File: rtl/pio_rx_fetch.sv
module pio_rx_fetch
    import rxf_pkg::*;
#(
    parameter int POLL_TRIES = 10,
    parameter int POLL_GAP   = 1000,
    parameter int HDR_WORDS  = 2,
    parameter int MAX_FRAMES = 10000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pass_bad_fcs,
    input  logic        frame_rdy,
    input  logic        data_rdy,
    input  logic [31:0] rd_word,
    output logic        frame_ack,
    output logic        discard,
    output logic        rd_pop,
    output logic        byte_valid,
    output logic [7:0]  byte_data,
    output logic        byte_sop,
    output logic        byte_eop,
    output logic        err_valid,
    output logic [2:0]  err_code
);
    localparam int HIDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;

    rxf_state_e        st_q;
    rxf_hdr_t          hdr_q;
    logic [HIDX_W-1:0] hidx_q;
    logic [15:0]       rem_q;
    logic [1:0]        bidx_q;
    logic              first_q;
    logic              pad_q;

    logic     t_sample, t_last, limit;
    rxf_err_e verdict;

    rxf_poll_timer #(.TRIES(POLL_TRIES), .GAP(POLL_GAP)) u_timer (
        .clk(clk), .rst(rst),
        .start(st_q == S_ACK), .run(st_q == S_POLL),
        .sample(t_sample), .last(t_last)
    );

    rxf_hdr_check u_check (.hdr(hdr_q), .pass_fcs(pass_bad_fcs), .verdict(verdict));

    rxf_burst_guard #(.MAX_FRAMES(MAX_FRAMES)) u_guard (
        .clk(clk), .rst(rst),
        .clear((st_q == S_IDLE || st_q == S_HOLD) && !frame_rdy),
        .take(st_q == S_ACK),
        .limit(limit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            hdr_q   <= '0;
            hidx_q  <= '0;
            rem_q   <= '0;
            bidx_q  <= '0;
            first_q <= 1'b0;
            pad_q   <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (frame_rdy) st_q <= limit ? S_HOLD : S_ACK;
                S_ACK:  st_q <= S_POLL;
                S_POLL: if (t_sample) begin
                    if (data_rdy) begin
                        st_q   <= S_HDR;
                        hidx_q <= '0;
                    end else if (t_last) begin
                        st_q <= S_IDLE;
                    end
                end
                S_HDR: begin
                    if (hidx_q == HIDX_W'(0)) hdr_q.len <= rd_word[15:0];
                    if (hidx_q == HIDX_W'(1)) begin
                        hdr_q.fcs_bad <= rd_word[FCS_BIT];
                        hdr_q.pad     <= rd_word[PAD_BIT];
                    end
                    if (hidx_q == HIDX_W'(HDR_WORDS - 1)) st_q <= S_CHECK;
                    else hidx_q <= hidx_q + 1'b1;
                end
                S_CHECK: begin
                    if (verdict != ERR_NONE) begin
                        st_q <= S_IDLE;
                    end else begin
                        rem_q   <= hdr_q.len;
                        bidx_q  <= '0;
                        first_q <= 1'b1;
                        pad_q   <= 1'b0;
                        st_q    <= hdr_q.pad ? S_PAD : S_DATA;
                    end
                end
                S_PAD: begin
                    first_q <= 1'b0;
                    pad_q   <= 1'b1;
                    if (pad_q) st_q <= S_DATA;
                end
                S_DATA: begin
                    first_q <= 1'b0;
                    bidx_q  <= bidx_q + 1'b1;
                    rem_q   <= rem_q - 1'b1;
                    if (rem_q == 16'd1) st_q <= S_IDLE;
                end
                S_HOLD: if (!frame_rdy) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        frame_ack  = (st_q == S_ACK);
        discard    = (st_q == S_CHECK) && (verdict != ERR_NONE);
        rd_pop     = (st_q == S_HDR) ||
                     ((st_q == S_DATA) && (bidx_q == 2'd3 || rem_q == 16'd1));
        byte_valid = (st_q == S_PAD) || (st_q == S_DATA);
        byte_data  = (st_q == S_DATA) ? rd_word[{bidx_q, 3'b000} +: 8] : 8'h00;
        byte_sop   = byte_valid && first_q;
        byte_eop   = (st_q == S_DATA) && (rem_q == 16'd1);
        err_valid  = 1'b0;
        err_code   = ERR_NONE;
        if (st_q == S_POLL && t_sample && !data_rdy && t_last) begin
            err_valid = 1'b1;
            err_code  = ERR_TIMEOUT;
        end else if (discard) begin
            err_valid = 1'b1;
            err_code  = verdict;
        end else if (st_q == S_IDLE && frame_rdy && limit) begin
            err_valid = 1'b1;
            err_code  = ERR_BURST;
        end
    end
endmodule

// File: rtl/rxf_fetch_chk.sv
module rxf_fetch_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_rdy,
    input logic       frame_ack,
    input logic       discard,
    input logic       rd_pop,
    input logic       byte_valid,
    input logic       byte_sop,
    input logic       byte_eop,
    input logic       err_valid,
    input logic [2:0] err_code
);
    p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
        frame_ack |=> !frame_ack);

    p_ack_after_ready_r2: assert property (@(posedge clk) disable iff (rst)
        frame_ack |-> $past(frame_rdy));

    p_timeout_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == 3'd1) |-> (!rd_pop && !byte_valid && !discard));

    p_discard_reports_r5: assert property (@(posedge clk) disable iff (rst)
        discard |-> (err_valid && (err_code == 3'd2 || err_code == 3'd3) && !byte_valid));

    p_markers_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_sop || byte_eop) |-> byte_valid);

    p_eop_ends_r9: assert property (@(posedge clk) disable iff (rst)
        byte_eop |=> !byte_valid);

    p_burst_no_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == 3'd4) |=> !frame_ack);
endmodule

bind pio_rx_fetch rxf_fetch_chk u_chk (.*);

// File: tb/sim_pio_rx_fetch.sv
`timescale 1ns/1ps
module sim_pio_rx_fetch;
    localparam int TRIES = 10;
    localparam int GAP   = 3;
    localparam int MAXF  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pass_bad_fcs = 1'b0;
    logic frame_rdy = 1'b0;
    logic data_rdy  = 1'b0;
    logic [31:0] rd_word;
    logic frame_ack, discard, rd_pop, byte_valid, byte_sop, byte_eop, err_valid;
    logic [7:0] byte_data;
    logic [2:0] err_code;

    always #5 clk = ~clk;

    pio_rx_fetch #(.POLL_TRIES(TRIES), .POLL_GAP(GAP), .HDR_WORDS(2), .MAX_FRAMES(MAXF)) u0 (
        .clk(clk), .rst(rst), .pass_bad_fcs(pass_bad_fcs),
        .frame_rdy(frame_rdy), .data_rdy(data_rdy), .rd_word(rd_word),
        .frame_ack(frame_ack), .discard(discard), .rd_pop(rd_pop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_sop(byte_sop), .byte_eop(byte_eop),
        .err_valid(err_valid), .err_code(err_code)
    );

    // FIFO model
    logic [31:0] mem [0:511];
    int ptr = 0;
    int cfg_dly = 0;
    bit cfg_nodata = 1'b0;
    int dly_cnt = 0;
    bit arm = 1'b0;

    assign rd_word = (ptr < 512) ? mem[ptr] : 32'h0;

    always @(posedge clk) begin
        if (frame_ack) begin
            ptr      <= 0;
            data_rdy <= 1'b0;
            dly_cnt  <= cfg_dly;
            arm      <= !cfg_nodata;
        end else begin
            if (rd_pop) ptr <= ptr + 1;
            if (discard) data_rdy <= 1'b0;
            if (arm) begin
                if (dly_cnt == 0) begin
                    data_rdy <= 1'b1;
                    arm      <= 1'b0;
                end else dly_cnt <= dly_cnt - 1;
            end
        end
    end

    // Output monitor
    logic [7:0] cap [0:4095];
    bit cap_sop [0:4095];
    bit cap_eop [0:4095];
    int cap_n = 0, acks = 0, pops = 0, discs = 0, errs = 0, sops = 0, eops = 0;
    int last_err = 0, cyc = 0, ack_cyc = 0, err_cyc = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (frame_ack) begin acks <= acks + 1; ack_cyc <= cyc; end
            if (rd_pop) pops <= pops + 1;
            if (discard) discs <= discs + 1;
            if (err_valid) begin errs <= errs + 1; last_err <= int'(err_code); err_cyc <= cyc; end
            if (byte_sop) sops <= sops + 1;
            if (byte_eop) eops <= eops + 1;
            if (byte_valid && cap_n < 4096) begin
                cap[cap_n]     <= byte_data;
                cap_sop[cap_n] <= byte_sop;
                cap_eop[cap_n] <= byte_eop;
                cap_n <= cap_n + 1;
            end
        end
    end

    int tests = 0, fails = 0;
    int b0, a0, p0, d0, e0, s0, eo0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'((seed + i * 7) & 8'hFF);
    endfunction

    task automatic snap();
        b0 = cap_n; a0 = acks; p0 = pops; d0 = discs; e0 = errs; s0 = sops; eo0 = eops;
    endtask

    task automatic send(input int len, input logic [31:0] st, input bit psf,
                        input int dly, input bit nodata, input int seed);
        for (int i = 0; i < 512; i++) mem[i] = 32'h0;
        mem[0] = 32'(len) | 32'hABCD_0000;
        mem[1] = st;
        for (int i = 0; i < len && i < 2040; i++)
            mem[2 + i / 4][(i % 4) * 8 +: 8] = pbyte(seed, i);
        if (len > 0 && (len % 4) != 0)
            mem[2 + len / 4][31:24] = 8'hEE;
        cfg_dly = dly; cfg_nodata = nodata; pass_bad_fcs = psf;
        snap();
        @(negedge clk);
        frame_rdy = 1'b1;
        for (int k = 0; k < 100 && acks == a0; k++) @(negedge clk);
        frame_rdy = 1'b0;
        for (int k = 0; k < 4000 && eops == eo0 && errs == e0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_delivery(input string tag, input int len, input int npad, input int seed);
        int n;
        n = cap_n - b0;
        chk(n == len + npad, {tag, " byte count"}, n, len + npad);
        chk(errs == e0, {tag, " no error"}, errs - e0, 0);
        chk(sops - s0 == 1 && cap_sop[b0], {tag, " R9 single sop on first"}, sops - s0, 1);
        chk(eops - eo0 == 1 && cap_eop[b0 + n - 1], {tag, " R9 single eop on last"}, eops - eo0, 1);
        for (int i = 0; i < npad; i++)
            chk(cap[b0 + i] == 8'h00, {tag, " R7 pad byte zero"}, int'(cap[b0 + i]), 0);
        begin
            int bad = 0;
            for (int i = 0; i < len; i++)
                if (cap[b0 + npad + i] != pbyte(seed, i)) bad++;
            chk(bad == 0, {tag, " R8 payload bytes"}, bad, 0);
        end
        chk(pops - p0 == 2 + (len + 3) / 4, {tag, " R4 R8 pop count"}, pops - p0, 2 + (len + 3) / 4);
    endtask

    task automatic t_reset();
        chk(!frame_ack && !discard && !rd_pop && !byte_valid && !byte_sop && !byte_eop &&
            !err_valid && byte_data == 8'h00 && err_code == 3'd0, "R1 reset outputs", 0, 0);
    endtask

    task automatic t_idle();
        snap();
        repeat (20) @(negedge clk);
        chk(acks == a0 && pops == p0 && cap_n == b0, "R2 idle without frame_rdy", acks - a0, 0);
    endtask

    task automatic t_basic();
        send(6, 32'h0, 1'b0, 0, 1'b0, 11);
        chk(acks - a0 == 1, "R2 one acknowledge", acks - a0, 1);
        check_delivery("basic len6", 6, 0, 11);
    endtask

    task automatic t_pad();
        send(5, 32'h4, 1'b0, 0, 1'b0, 40);
        check_delivery("R7 padded len5", 5, 2, 40);
    endtask

    task automatic t_one();
        send(1, 32'h0, 1'b0, 0, 1'b0, 99);
        check_delivery("R9 len1", 1, 0, 99);
    endtask

    task automatic t_len_bad();
        send(0, 32'h0, 1'b0, 0, 1'b0, 1);
        chk(last_err == 2 && errs - e0 == 1, "R5 zero length code", last_err, 2);
        chk(discs - d0 == 1 && cap_n == b0, "R5 zero length discard", discs - d0, 1);
        chk(pops - p0 == 2, "R4 header only popped", pops - p0, 2);
        send(16'h701, 32'h0, 1'b0, 0, 1'b0, 1);
        chk(last_err == 2 && discs - d0 == 1 && cap_n == b0, "R5 length 0x701", last_err, 2);
    endtask

    task automatic t_len_max();
        send(16'h700, 32'h0, 1'b0, 0, 1'b0, 5);
        check_delivery("R5 length 0x700", 16'h700, 0, 5);
    endtask

    task automatic t_fcs();
        send(4, 32'h1, 1'b0, 0, 1'b0, 3);
        chk(last_err == 3 && discs - d0 == 1 && cap_n == b0, "R6 checksum drop", last_err, 3);
        send(4, 32'h1, 1'b1, 0, 1'b0, 3);
        check_delivery("R6 checksum passed", 4, 0, 3);
        send(0, 32'h1, 1'b0, 0, 1'b0, 3);
        chk(last_err == 2, "R6 length before checksum", last_err, 2);
    endtask

    task automatic t_late();
        send(7, 32'h0, 1'b0, 15, 1'b0, 21);
        check_delivery("R3 late data", 7, 0, 21);
    endtask

    task automatic t_timeout();
        send(4, 32'h0, 1'b0, 0, 1'b1, 0);
        chk(last_err == 1 && errs - e0 == 1, "R3 timeout code", last_err, 1);
        chk(pops == p0 && discs == d0 && cap_n == b0, "R3 timeout no pop", pops - p0, 0);
        chk(err_cyc - ack_cyc == 1 + (TRIES - 1) * GAP, "R3 timeout cycle",
            err_cyc - ack_cyc, 1 + (TRIES - 1) * GAP);
    endtask

    task automatic t_burst();
        cfg_nodata = 1'b1;
        snap();
        @(negedge clk);
        frame_rdy = 1'b1;
        for (int k = 0; k < 2000 && !(errs != e0 && last_err == 4); k++) @(negedge clk);
        chk(last_err == 4, "R10 burst limit code", last_err, 4);
        chk(acks - a0 == MAXF, "R10 acknowledges before limit", acks - a0, MAXF);
        a0 = acks;
        repeat (50) @(negedge clk);
        chk(acks == a0, "R10 held while frame_rdy high", acks - a0, 0);
        frame_rdy = 1'b0;
        repeat (3) @(negedge clk);
        send(3, 32'h0, 1'b0, 0, 1'b0, 60);
        check_delivery("R10 resumes after drop", 3, 0, 60);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_idle();
        t_basic();
        t_pad();
        t_one();
        t_len_bad();
        t_len_max();
        t_fcs();
        t_late();
        t_timeout();
        t_burst();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule